// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Datapath

This block is an in-order, five-stage processor core for a small 32-bit load/store instruction subset: word load, word store and the register-to-register operations add, subtract, bitwise AND and bitwise OR. The stages are fetch, decode, execute, memory and writeback. The PC advances by four on every clock. A separate instruction memory and data memory let fetch and a data access happen in the same cycle. Four free-running pipeline registers sit between the stages. Each one carries an instruction's operands along with its control bits, and the control bits are grouped by the stage that consumes them.

There is no forwarding, no stall and no hazard detection. A consumer placed one or two instructions after its producer reads the old register value, and this outcome is deterministic. A consumer three instructions later sees the new value, because a writeback and a decode read of the same register in one cycle return the freshly written data. Programs, data words and initial register contents are written through a shared load port, and only while reset is held. Results are observed through a register read-back port and through a per-instruction retire trace.

Top module: `pipe5_core`

## Requirements
- R1: After reset is released, the PC starts at RESET_PC (default 1000) and advances by 4 every clock. The k-th recognised instruction of a program (counting from 0) appears on the retire trace in cycle k+5, where cycle 1 is the first cycle after reset is released.
- R2: Opcode 0x23 is a load and opcode 0x2B is a store. Opcode 0x00 is a register operation whose funct field (bits 5-0) selects 0x20 add, 0x22 sub, 0x24 and, or 0x25 or. Any other encoding is a bubble: it writes nothing and never appears on the retire trace.
- R3: A load writes the data word at index (rs + sign-extended bits 15-0) >> 2, modulo the data memory depth, into register rt. The rs field is bits 25-21 and the rt field is bits 20-16.
- R4: A store writes register rt to the data word at index (rs + sign-extended imm) >> 2. A later load from that word returns the stored value.
- R5: A register operation writes rs op rt into register rd (bits 15-11), using 32-bit wrap-around arithmetic.
- R6: Register 0 always reads as zero, whatever was loaded into it, and writes that name it are discarded.
- R7: An instruction three positions after a producer reads the producer's result, because a writeback in a cycle is visible to a decode read in the same cycle.
- R8: An instruction one or two positions after a producer reads the register value from before the producer executed.
- R9: While reset is held, and during pipeline fill, the retire trace shows no valid instruction and no register or memory write occurs.
- R10: During an instruction's writeback cycle, ret_valid is 1 and ret_we is 1 for loads and register operations, including those that name register 0. For those instructions ret_dst is the destination register and ret_data is the value written. A store retires with ret_we at 0.
- R11: Load port: when ld_we is 1 while rst_n is 0, ld_sel selects the target (0 instruction memory, 1 data memory, 2 register file) and ld_idx gives the word or register index.
- R12: dbg_data returns, combinationally, the committed content of register dbg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loading is allowed only while low |
| ld_we | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 instruction memory, 1 data memory, 2 register file |
| ld_idx | input | LD_AW | Word index or register number for the load |
| ld_data | input | 32 | Load data |
| dbg_idx | input | 5 | Register selected for read-back |
| dbg_data | output | 32 | Committed value of register dbg_idx |
| ret_valid | output | 1 | A recognised instruction is in writeback |
| ret_we | output | 1 | That instruction writes a register |
| ret_dst | output | 5 | Its destination register |
| ret_data | output | 32 | Its writeback value |

## Verification
Two of the block's functions can fall in the same cycle: the writeback of one instruction and the decode read of the same register by the instruction three positions behind it. A directed program puts consumers at distances one, two and three from an add, so the bench can confirm that the first two read the stale value and the third reads the new one. Seeded random programs then create the same collision densely, along with a load and a store in the memory stage while a fetch proceeds. All of these are judged against a bench model in which each instruction reads the register state that excludes the writes of the two instructions just before it. Both the per-cycle retire trace and the final register contents are compared with that model.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN = 32;
    localparam int NREGS = 32;
    typedef logic [XLEN-1:0] word_t;
    typedef logic [4:0]      ridx_t;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;
    localparam logic [5:0] FN_AND   = 6'h24;
    localparam logic [5:0] FN_OR    = 6'h25;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;

    // control consumed in execute
    typedef struct packed {
        logic    dst_is_rd;
        logic    use_imm;
        alu_op_e op;
    } ex_ctl_t;

    // control consumed in memory
    typedef struct packed {
        logic rd_en;
        logic wr_en;
    } mem_ctl_t;

    // control consumed in writeback
    typedef struct packed {
        logic reg_wr;
        logic from_mem;
    } wb_ctl_t;

    typedef struct packed {
        logic     live;
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } ctl_t;

    typedef struct packed {
        logic     live;
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
        word_t    a;
        word_t    b;
        word_t    imm;
        ridx_t    rt;
        ridx_t    rd;
    } idex_t;

    typedef struct packed {
        logic     live;
        mem_ctl_t mem;
        wb_ctl_t  wb;
        word_t    y;
        word_t    st;
        ridx_t    dst;
    } exmem_t;

    typedef struct packed {
        logic    live;
        wb_ctl_t wb;
        word_t   y;
        word_t   ld;
        ridx_t   dst;
    } memwb_t;

    localparam ctl_t CTL_BUBBLE = '0;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);
    alu_op_e fn_op;
    logic    fn_known;

    always_comb begin
        fn_op    = ALU_ADD;
        fn_known = 1'b1;
        unique case (funct)
            FN_ADD:  fn_op = ALU_ADD;
            FN_SUB:  fn_op = ALU_SUB;
            FN_AND:  fn_op = ALU_AND;
            FN_OR:   fn_op = ALU_OR;
            default: fn_known = 1'b0;
        endcase
    end

    always_comb begin
        ctl = CTL_BUBBLE;
        unique case (opcode)
            OP_LOAD: begin
                ctl.live        = 1'b1;
                ctl.ex.use_imm  = 1'b1;
                ctl.ex.op       = ALU_ADD;
                ctl.mem.rd_en   = 1'b1;
                ctl.wb.reg_wr   = 1'b1;
                ctl.wb.from_mem = 1'b1;
            end
            OP_STORE: begin
                ctl.live       = 1'b1;
                ctl.ex.use_imm = 1'b1;
                ctl.ex.op      = ALU_ADD;
                ctl.mem.wr_en  = 1'b1;
            end
            OP_REG: begin
                if (fn_known) begin
                    ctl.live         = 1'b1;
                    ctl.ex.dst_is_rd = 1'b1;
                    ctl.ex.op        = fn_op;
                    ctl.wb.reg_wr    = 1'b1;
                end
            end
            default: ctl = CTL_BUBBLE;
        endcase
    end
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ridx_t rd_idx  [NRD],
    output word_t rd_data [NRD],
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_data,
    input  logic  ld_en,
    input  ridx_t ld_idx,
    input  word_t ld_data,
    input  ridx_t peek_idx,
    output word_t peek_data
);
    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            regs[ld_idx] <= ld_data;
        end else if (wr_en && wr_idx != '0) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // read ports: writeback data overtakes the array within the same cycle
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0)
                rd_data[p] = '0;
            else if (wr_en && wr_idx == rd_idx[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = regs[rd_idx[p]];
        end

        a_r6_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_idx[p] == '0) |-> (rd_data[p] == '0));
    end

    assign peek_data = (peek_idx == '0) ? '0 : regs[peek_idx];

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && !ld_en) |=> (regs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int    IMEM_AW  = 8,
    parameter int    DMEM_AW  = 6,
    parameter logic [31:0] RESET_PC = 32'd1000,
    parameter int    LD_AW    = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [1:0]       ld_sel,
    input  logic [LD_AW-1:0] ld_idx,
    input  logic [31:0]      ld_data,
    input  logic [4:0]       dbg_idx,
    output logic [31:0]      dbg_data,
    output logic             ret_valid,
    output logic             ret_we,
    output logic [4:0]       ret_dst,
    output logic [31:0]      ret_data
);
    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;
    localparam logic [1:0] SEL_IMEM = 2'd0;
    localparam logic [1:0] SEL_DMEM = 2'd1;
    localparam logic [1:0] SEL_REGS = 2'd2;

    logic ld_imem, ld_dmem, ld_regs;
    assign ld_imem = !rst_n && ld_we && (ld_sel == SEL_IMEM);
    assign ld_dmem = !rst_n && ld_we && (ld_sel == SEL_DMEM);
    assign ld_regs = !rst_n && ld_we && (ld_sel == SEL_REGS);

    // ---------------- fetch ----------------
    word_t pc;
    word_t imem [IMEM_WORDS];
    word_t if_instr;
    word_t ifid_instr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= pc + 32'd4;
    end

    always_ff @(posedge clk) begin
        if (ld_imem) imem[ld_idx[IMEM_AW-1:0]] <= ld_data;
    end

    assign if_instr = imem[pc[IMEM_AW+1:2]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ifid_instr <= '0;
        else        ifid_instr <= if_instr;
    end

    // ---------------- decode ----------------
    ctl_t  id_ctl;
    ridx_t rf_rd_idx  [2];
    word_t rf_rd_data [2];
    logic  wb_we;
    word_t wb_val;
    idex_t idex;
    memwb_t memwb;

    pipe5_decode u_dec (
        .opcode (ifid_instr[31:26]),
        .funct  (ifid_instr[5:0]),
        .ctl    (id_ctl)
    );

    assign rf_rd_idx[0] = ifid_instr[25:21];
    assign rf_rd_idx[1] = ifid_instr[20:16];

    pipe5_regfile #(.NRD(2)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (rf_rd_idx),
        .rd_data   (rf_rd_data),
        .wr_en     (wb_we),
        .wr_idx    (memwb.dst),
        .wr_data   (wb_val),
        .ld_en     (ld_regs),
        .ld_idx    (ld_idx[4:0]),
        .ld_data   (ld_data),
        .peek_idx  (dbg_idx),
        .peek_data (dbg_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idex <= '0;
        end else begin
            idex.live <= id_ctl.live;
            idex.ex   <= id_ctl.ex;
            idex.mem  <= id_ctl.mem;
            idex.wb   <= id_ctl.wb;
            idex.a    <= rf_rd_data[0];
            idex.b    <= rf_rd_data[1];
            idex.imm  <= {{16{ifid_instr[15]}}, ifid_instr[15:0]};
            idex.rt   <= ifid_instr[20:16];
            idex.rd   <= ifid_instr[15:11];
        end
    end

    // ---------------- execute ----------------
    word_t  ex_b;
    word_t  ex_y;
    exmem_t exmem;

    assign ex_b = idex.ex.use_imm ? idex.imm : idex.b;

    pipe5_alu u_alu (
        .op (idex.ex.op),
        .a  (idex.a),
        .b  (ex_b),
        .y  (ex_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exmem <= '0;
        end else begin
            exmem.live <= idex.live;
            exmem.mem  <= idex.mem;
            exmem.wb   <= idex.wb;
            exmem.y    <= ex_y;
            exmem.st   <= idex.b;
            exmem.dst  <= idex.ex.dst_is_rd ? idex.rd : idex.rt;
        end
    end

    // ---------------- memory ----------------
    word_t dmem [DMEM_WORDS];
    word_t mem_rd;
    logic [DMEM_AW-1:0] mem_idx;

    assign mem_idx = exmem.y[DMEM_AW+1:2];

    always_ff @(posedge clk) begin
        if (ld_dmem)
            dmem[ld_idx[DMEM_AW-1:0]] <= ld_data;
        else if (exmem.mem.wr_en)
            dmem[mem_idx] <= exmem.st;
    end

    assign mem_rd = exmem.mem.rd_en ? dmem[mem_idx] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            memwb <= '0;
        end else begin
            memwb.live <= exmem.live;
            memwb.wb   <= exmem.wb;
            memwb.y    <= exmem.y;
            memwb.ld   <= mem_rd;
            memwb.dst  <= exmem.dst;
        end
    end

    // ---------------- writeback ----------------
    assign wb_val = memwb.wb.from_mem ? memwb.ld : memwb.y;
    assign wb_we  = memwb.live && memwb.wb.reg_wr;

    assign ret_valid = memwb.live;
    assign ret_we    = memwb.wb.reg_wr;
    assign ret_dst   = memwb.dst;
    assign ret_data  = wb_val;

    // ---------------- checks ----------------
    a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pc == $past(pc) + 32'd4));

    a_r2_mem_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exmem.mem.rd_en, exmem.mem.wr_en}));

    a_r9_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !exmem.live |-> !(exmem.mem.wr_en || exmem.mem.rd_en || exmem.wb.reg_wr));

    a_r10_stage_flow: assert property (@(posedge clk) disable iff (!rst_n)
        memwb.live |-> $past(exmem.live));
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
    import pipe5_pkg::*;

    localparam int IAW  = 8;
    localparam int DAW  = 6;
    localparam int LAW  = 8;
    localparam int NI   = 1 << IAW;
    localparam int ND   = 1 << DAW;
    localparam int PC0  = 1000;
    localparam int MAXP = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n   = 1'b0;
    logic           ld_we   = 1'b0;
    logic [1:0]     ld_sel  = 2'd0;
    logic [LAW-1:0] ld_idx  = '0;
    word_t          ld_data = '0;
    ridx_t          dbg_idx = '0;
    word_t          dbg_data;
    logic           ret_valid, ret_we;
    ridx_t          ret_dst;
    word_t          ret_data;

    pipe5_core #(.IMEM_AW(IAW), .DMEM_AW(DAW), .RESET_PC(PC0)) dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_idx(ld_idx),
        .ld_data(ld_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data),
        .ret_valid(ret_valid), .ret_we(ret_we), .ret_dst(ret_dst), .ret_data(ret_data)
    );

    int errs = 0;
    int checks = 0;

    word_t prog [MAXP];
    int    plen = 0;
    word_t rinit [32];
    word_t dinit [ND];
    word_t mreg [32];
    word_t mmem [ND];
    logic  e_ret [MAXP];
    logic  e_we  [MAXP];
    ridx_t e_dst [MAXP];
    word_t e_val [MAXP];
    string e_tag [MAXP];

    task automatic check(input logic ok, input string req, input string what,
                         input word_t act, input word_t exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic word_t enc_r(input ridx_t rs, input ridx_t rt, input ridx_t rd,
                                    input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic word_t enc_i(input logic [5:0] op, input ridx_t rs, input ridx_t rt,
                                    input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic void commit(input int j);
        if (e_ret[j] && e_we[j] && e_dst[j] != 5'd0) mreg[e_dst[j]] = e_val[j];
    endfunction

    // reference: instruction i sees writes of instructions up to i-3 only (R7, R8)
    function automatic void model();
        for (int r = 0; r < 32; r++) mreg[r] = rinit[r];
        for (int d = 0; d < ND; d++) mmem[d] = dinit[d];
        for (int i = 0; i < plen; i++) begin
            logic [5:0] op, fn;
            ridx_t rs, rt, rd;
            word_t a, b, imm, addr;
            if (i >= 3) commit(i - 3);
            op  = prog[i][31:26];
            fn  = prog[i][5:0];
            rs  = prog[i][25:21];
            rt  = prog[i][20:16];
            rd  = prog[i][15:11];
            a   = (rs == 5'd0) ? 32'd0 : mreg[rs];
            b   = (rt == 5'd0) ? 32'd0 : mreg[rt];
            imm = {{16{prog[i][15]}}, prog[i][15:0]};
            addr = a + imm;
            e_ret[i] = 1'b0; e_we[i] = 1'b0; e_dst[i] = '0; e_val[i] = '0; e_tag[i] = "R2";
            if (op == 6'h23) begin
                e_ret[i] = 1'b1; e_we[i] = 1'b1; e_dst[i] = rt;
                e_val[i] = mmem[addr[DAW+1:2]]; e_tag[i] = "R3";
            end else if (op == 6'h2B) begin
                mmem[addr[DAW+1:2]] = b;
                e_ret[i] = 1'b1; e_tag[i] = "R4";
            end else if (op == 6'h00) begin
                e_tag[i] = "R5";
                case (fn)
                    6'h20: begin e_ret[i] = 1'b1; e_val[i] = a + b; end
                    6'h22: begin e_ret[i] = 1'b1; e_val[i] = a - b; end
                    6'h24: begin e_ret[i] = 1'b1; e_val[i] = a & b; end
                    6'h25: begin e_ret[i] = 1'b1; e_val[i] = a | b; end
                    default: e_tag[i] = "R2";
                endcase
                if (e_ret[i]) begin e_we[i] = 1'b1; e_dst[i] = rd; end
            end
        end
        for (int j = (plen > 3) ? plen - 3 : 0; j < plen; j++) commit(j);
    endfunction

    task automatic load_one(input logic [1:0] sel, input int idx, input word_t d);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = sel; ld_idx = idx[LAW-1:0]; ld_data = d;
    endtask

    task automatic run_prog();
        word_t img [NI];
        model();
        @(negedge clk);
        rst_n = 1'b0;
        for (int w = 0; w < NI; w++) img[w] = '0;
        for (int i = 0; i < plen; i++) img[((PC0 >> 2) + i) % NI] = prog[i];
        for (int w = 0; w < NI; w++) load_one(2'd0, w, img[w]);   // R11
        for (int d = 0; d < ND; d++) load_one(2'd1, d, dinit[d]);
        for (int r = 0; r < 32; r++) load_one(2'd2, r, rinit[r]);
        @(negedge clk);
        ld_we = 1'b0;
        dbg_idx = 5'd0;
        #1;
        check(ret_valid == 1'b0, "R9", "trace idle in reset", {31'd0, ret_valid}, 32'd0);
        check(dbg_data == 32'd0, "R6", "reg0 reads zero after load", dbg_data, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;                                 // cycle 1 begins
        for (int c = 1; c <= plen + 6; c++) begin
            int k;
            @(posedge clk);
            @(negedge clk);
            k = c - 4;                                // instruction in writeback in cycle c+1
            if (k >= 0 && k < plen && e_ret[k]) begin
                check(ret_valid == 1'b1, "R1", $sformatf("retire slot %0d", k), {31'd0, ret_valid}, 32'd1);
                check(ret_we == e_we[k], "R10", $sformatf("we slot %0d", k), {31'd0, ret_we}, {31'd0, e_we[k]});
                if (e_we[k]) begin
                    check(ret_dst == e_dst[k], "R10", $sformatf("dst slot %0d", k), {27'd0, ret_dst}, {27'd0, e_dst[k]});
                    check(ret_data == e_val[k], e_tag[k], $sformatf("data slot %0d", k), ret_data, e_val[k]);
                end
            end else begin
                check(ret_valid == 1'b0, (k >= 0 && k < plen) ? "R2" : "R9",
                      $sformatf("no retire slot %0d", k), {31'd0, ret_valid}, 32'd0);
            end
        end
        for (int r = 0; r < 32; r++) begin
            dbg_idx = r[4:0];
            #1;
            check(dbg_data == ((r == 0) ? 32'd0 : mreg[r]), "R12",
                  $sformatf("readback reg %0d", r), dbg_data, (r == 0) ? 32'd0 : mreg[r]);
        end
    endtask

    task automatic read_reg(input int r, input word_t exp, input string req);
        dbg_idx = r[4:0];
        #1;
        check(dbg_data == exp, req, $sformatf("reg %0d", r), dbg_data, exp);
    endtask

    initial begin : watchdog
        #(4 * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);

        // directed: five-instruction overlap test, regs idx+100, data 99
        for (int r = 0; r < 32; r++) rinit[r] = 32'(r + 100);
        for (int d = 0; d < ND; d++) dinit[d] = 32'd99;
        plen = 5;
        prog[0] = enc_i(6'h23, 5'd29, 5'd8, 16'd4);
        prog[1] = enc_r(5'd4, 5'd5, 5'd2, 6'h22);
        prog[2] = enc_r(5'd10, 5'd11, 5'd9, 6'h24);
        prog[3] = enc_r(5'd17, 5'd18, 5'd16, 6'h25);
        prog[4] = enc_r(5'd14, 5'd0, 5'd13, 6'h20);
        run_prog();
        read_reg(8, 32'd99, "R3");
        read_reg(2, 32'hFFFF_FFFF, "R5");
        read_reg(9, 32'd110, "R5");
        read_reg(16, 32'd119, "R5");
        read_reg(13, 32'd114, "R5");

        // directed: hazard distances, register 0, store then load
        for (int d = 0; d < ND; d++) dinit[d] = 32'(d * 3);
        plen = 11;
        prog[0]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);    // r3 = 203
        prog[1]  = enc_r(5'd3, 5'd0, 5'd4, 6'h20);    // R8 distance 1
        prog[2]  = enc_r(5'd3, 5'd0, 5'd5, 6'h20);    // R8 distance 2
        prog[3]  = enc_r(5'd3, 5'd0, 5'd6, 6'h20);    // R7 distance 3
        prog[4]  = enc_r(5'd1, 5'd1, 5'd0, 6'h20);    // R6 write to r0
        prog[5]  = enc_i(6'h08, 5'd1, 5'd2, 16'd5);   // R2 unknown opcode
        prog[6]  = enc_r(5'd1, 5'd2, 5'd20, 6'h00);   // R2 unknown funct
        prog[7]  = enc_r(5'd0, 5'd0, 5'd7, 6'h20);
        prog[8]  = enc_i(6'h2B, 5'd0, 5'd6, 16'd8);   // R4 store r6
        prog[9]  = enc_i(6'h23, 5'd0, 5'd9, 16'd8);
        prog[10] = enc_i(6'h23, 5'd0, 5'd10, 16'd12);
        run_prog();
        read_reg(4, 32'd103, "R8");
        read_reg(5, 32'd103, "R8");
        read_reg(6, 32'd203, "R7");
        read_reg(7, 32'd0, "R6");
        read_reg(20, 32'd120, "R2");
        read_reg(9, 32'd203, "R4");
        read_reg(10, 32'd9, "R3");

        // random programs with dense dependences
        for (int t = 0; t < 20; t++) begin
            for (int r = 0; r < 32; r++) rinit[r] = $urandom();
            for (int d = 0; d < ND; d++) dinit[d] = $urandom();
            plen = 40;
            for (int i = 0; i < plen; i++) begin
                int kind;
                ridx_t rs, rt, rd;
                kind = $urandom_range(0, 7);
                rs = 5'($urandom_range(0, 7));
                rt = 5'($urandom_range(0, 7));
                rd = 5'($urandom_range(0, 7));
                case (kind)
                    0: prog[i] = enc_i(6'h23, 5'd0, rt, 16'(4 * $urandom_range(0, ND - 1)));
                    1: prog[i] = enc_i(6'h2B, 5'd0, rt, 16'(4 * $urandom_range(0, ND - 1)));
                    2: prog[i] = enc_r(rs, rt, rd, 6'h20);
                    3: prog[i] = enc_r(rs, rt, rd, 6'h22);
                    4: prog[i] = enc_r(rs, rt, rd, 6'h24);
                    5: prog[i] = enc_r(rs, rt, rd, 6'h25);
                    6: prog[i] = enc_i(6'h0D, rs, rt, 16'($urandom()));
                    default: prog[i] = enc_r(rs, rt, 5'd0, 6'h22);
                endcase
            end
            run_prog();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule